// File: doc/BRIEF.md
# Serial Management Interface Slave Controller

This block is the slave side of a two-wire serial management bus of the clause-22 kind. It samples the serial data line once per rising edge of the management clock, finds the frame start, collects a 12-bit header and then runs one of two transfers. A read fetches a 16-bit value from an attached register file and shifts it back to the master. A write collects 16 bits from the master and hands them to the register file with a single-cycle strobe.

Only one device sits behind the block, so the device-address field of the header is captured and then ignored. Preamble counting, clock generation and the register contents are left to the surrounding logic. The register-file port reads combinationally: the value on `reg_rdata` must reflect `reg_addr` within the cycle in which `reg_re` is high.

Any frame that breaks the protocol, such as an unknown opcode, sends the controller straight back to idle without touching the register file.

Top module: `mdio_slave_fsm`

## Requirements
- R1: A synchronous reset, applied at any point including mid-frame, returns the controller to idle: `mdio_oe`, `mdio_out`, `reg_re` and `reg_we` are all 0 in the cycle after reset, and the next complete frame is served normally.
- R2: In idle, a sampled 1 keeps the controller idle. A sampled 0 arms the start detector, further 0s keep it armed, and the first sampled 1 after that begins header capture.
- R3: The header is 12 bits, taken MSB first: opcode (2 bits), device address (5 bits, ignored for any value), register address (5 bits, the last five sampled).
- R4: Opcode 2'b10 is a read. In the cycle after the last header bit, `reg_re` is high for exactly one cycle with `reg_addr` set to the header register address. In that cycle `mdio_oe` is 1 and `mdio_out` is 0, which forms the one-bit turnaround.
- R5: In the 16 cycles after the read turnaround, `mdio_oe` is 1 and `mdio_out` carries the fetched value MSB first, one bit per cycle. In the cycle after that, `mdio_oe` is 0.
- R6: Opcode 2'b01 is a write. The two bits sampled after the header are skipped whatever their values, and the next 16 sampled bits form the data, MSB first. In the cycle after the 16th data bit, `reg_we` pulses for one cycle with `reg_addr` and `reg_wdata` holding the captured address and data.
- R7: Opcodes 2'b00 and 2'b11 return the controller to idle after the header. No strobe fires, `mdio_oe` stays 0, and a following valid frame is served.
- R8: `mdio_oe` is high only in read turnaround and read data: exactly 17 cycles per read, and never during a write or an invalid frame.
- R9: `reg_re` and `reg_we` are never high together, and each is a single-cycle pulse per accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mdio_in | input | 1 | Sampled state of the serial data line |
| mdio_out | output | 1 | Value driven onto the data line while enabled |
| mdio_oe | output | 1 | Output enable for the data line driver |
| reg_addr | output | 5 | Register address toward the register file |
| reg_wdata | output | 16 | Write data toward the register file |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 16 | Combinational read data from the register file |

## Verification
The bench builds the block with its default widths: 16-bit data, 5-bit register and device addresses, and a 2-bit opcode. These widths let every one of the 32 register addresses be reached, including the edge addresses 0 and 31, along with all four opcode values and arbitrary device-address fields. They also keep the 17-cycle read window and the 18-bit write tail short enough for many randomized frames of mixed kind, start-delay length and turnaround content. A reset is also injected during a read's data phase.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HDR,
        ST_TA_RD,
        ST_RD_DATA,
        ST_TA_WR,
        ST_WR_DATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_bit_counter.sv
`timescale 1ns/1ps
// Down-counter that tracks the remaining bits of the current frame field.
module mdio_bit_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (dec_i)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CNT_W'(1));

    // R3/R5/R6: every field is loaded before it is counted down
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/mdio_tx_driver.sv
`timescale 1ns/1ps
// Holds the fetched read value and drives the line during a read.
module mdio_tx_driver
    import mdio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  mdio_state_e       state_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              out_o,
    output logic              oe_o
);
    logic [DATA_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (state_i == ST_TA_RD)
            sh_d = rdata_i;
        else if (state_i == ST_RD_DATA)
            sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign oe_o  = (state_i == ST_TA_RD) || (state_i == ST_RD_DATA);
    assign out_o = (state_i == ST_RD_DATA) ? sh_q[DATA_W-1] : 1'b0;
endmodule

// File: rtl/mdio_slave_fsm.sv
`timescale 1ns/1ps
module mdio_slave_fsm
    import mdio_pkg::*;
#(
    parameter int         DATA_W   = 16,
    parameter int         ADDR_W   = 5,
    parameter int         DEV_W    = 5,
    parameter int         OP_W     = 2,
    parameter logic [1:0] OP_READ  = 2'b10,
    parameter logic [1:0] OP_WRITE = 2'b01,
    parameter int         TA_WR_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int HDR_W = OP_W + DEV_W + ADDR_W;
    localparam int ACC_W = (DATA_W > HDR_W) ? DATA_W : HDR_W;
    localparam int MAXF  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
    localparam int CNT_W = $clog2(MAXF + 1);

    typedef struct packed {
        mdio_state_e       state;
        logic [ACC_W-1:0]  acc;
        logic [ADDR_W-1:0] addr;
        logic              we;
    } ctl_t;

    ctl_t             r_d, r_q;
    logic             cnt_load, cnt_dec, cnt_last;
    logic [CNT_W-1:0] cnt_val;
    logic [OP_W-1:0]  op_d;

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        op_d     = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (!mdio_in) r_d.state = ST_START;
            end
            ST_START: begin
                if (mdio_in) begin
                    r_d.state = ST_HDR;
                    r_d.acc   = '0;
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(HDR_W);
                end
            end
            ST_HDR: begin
                r_d.acc = {r_q.acc[ACC_W-2:0], mdio_in};
                cnt_dec = 1'b1;
                if (cnt_last) begin
                    op_d     = r_d.acc[HDR_W-1 -: OP_W];
                    r_d.addr = r_d.acc[ADDR_W-1:0];
                    if (op_d == OP_READ) begin
                        r_d.state = ST_TA_RD;
                    end else if (op_d == OP_WRITE) begin
                        r_d.state = ST_TA_WR;
                        cnt_load  = 1'b1;
                        cnt_val   = CNT_W'(TA_WR_BITS);
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_TA_RD: begin
                r_d.state = ST_RD_DATA;
                cnt_load  = 1'b1;
                cnt_val   = CNT_W'(DATA_W);
            end
            ST_RD_DATA: begin
                cnt_dec = 1'b1;
                if (cnt_last) r_d.state = ST_IDLE;
            end
            ST_TA_WR: begin
                cnt_dec = 1'b1;
                if (cnt_last) begin
                    r_d.state = ST_WR_DATA;
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(DATA_W);
                end
            end
            ST_WR_DATA: begin
                r_d.acc = {r_q.acc[ACC_W-2:0], mdio_in};
                cnt_dec = 1'b1;
                if (cnt_last) begin
                    r_d.we    = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
            r_q.acc   <= '0;
            r_q.addr  <= '0;
            r_q.we    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    mdio_bit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .dec_i      (cnt_dec),
        .last_o     (cnt_last)
    );

    mdio_tx_driver #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .state_i (r_q.state),
        .rdata_i (reg_rdata),
        .out_o   (mdio_out),
        .oe_o    (mdio_oe)
    );

    assign reg_addr  = r_q.addr;
    assign reg_wdata = r_q.acc[DATA_W-1:0];
    assign reg_we    = r_q.we;
    assign reg_re    = (r_q.state == ST_TA_RD);

    a_r4_ta_driven_low: assert property (@(posedge clk) disable iff (rst)
        reg_re |-> (mdio_oe && !mdio_out));
    a_r5_first_bit: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> (mdio_oe && (mdio_out == $past(reg_rdata[DATA_W-1]))));
    a_r8_no_oe_on_write: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !mdio_oe);
    a_r9_we_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);
    a_r9_re_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_re && reg_we));
endmodule

// File: tb/test_mdio_slave_fsm.sv
`timescale 1ns/1ps
module test_mdio_slave_fsm;
    localparam int DW = 16;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mdio_in = 1'b1;
    logic          mdio_out, mdio_oe, reg_we, reg_re;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata, reg_rdata;

    logic [DW-1:0] mem [32];
    logic [DW-1:0] exp_mem [32];
    int n_tests = 0, n_fail = 0;
    int re_cnt = 0, we_cnt = 0, oe_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mdio_slave_fsm i_mdio_slave_fsm (
        .clk(clk), .rst(rst), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;
    always @(negedge clk) begin
        if (reg_re)  re_cnt++;
        if (reg_we)  we_cnt++;
        if (mdio_oe) oe_cnt++;
    end

    function automatic logic [DW-1:0] init_val(int a);
        return 16'hC35A ^ DW'(a * 16'h0913);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clk_bit(bit b);
        @(negedge clk);
        mdio_in = b;
        @(posedge clk);
    endtask

    task automatic send_hdr(logic [1:0] op, logic [4:0] dev, logic [4:0] ra, int zeros);
        clk_bit(1); clk_bit(1);
        for (int i = 0; i <= zeros; i++) clk_bit(0);
        clk_bit(1);
        for (int i = 1; i >= 0; i--) clk_bit(op[i]);
        for (int i = 4; i >= 0; i--) clk_bit(dev[i]);
        for (int i = 4; i >= 0; i--) clk_bit(ra[i]);
    endtask

    task automatic do_read(logic [4:0] dev, logic [4:0] ra, int zeros);
        int b_re = re_cnt, b_we = we_cnt, b_oe = oe_cnt;
        logic [DW-1:0] v = exp_mem[ra];
        send_hdr(2'b10, dev, ra, zeros);
        @(negedge clk);
        mdio_in = 1;
        chk("R4 re", reg_re, 1);
        chk("R3 addr", reg_addr, ra);
        chk("R4 ta", {mdio_oe, mdio_out}, 2'b10);
        @(posedge clk);
        for (int i = DW - 1; i >= 0; i--) begin
            @(negedge clk);
            chk("R5 data", {mdio_oe, mdio_out}, {1'b1, v[i]});
            @(posedge clk);
        end
        @(negedge clk);
        chk("R5 oe off", mdio_oe, 0);
        #1;
        chk("R9 re once", re_cnt - b_re, 1);
        chk("R9 no we", we_cnt - b_we, 0);
        chk("R8 oe cycles", oe_cnt - b_oe, 17);
    endtask

    task automatic do_write(logic [4:0] dev, logic [4:0] ra, logic [DW-1:0] d, int zeros);
        int b_re = re_cnt, b_we = we_cnt, b_oe = oe_cnt;
        send_hdr(2'b01, dev, ra, zeros);
        clk_bit(1'($urandom)); clk_bit(1'($urandom));
        for (int i = DW - 1; i >= 0; i--) clk_bit(d[i]);
        @(negedge clk);
        mdio_in = 1;
        chk("R6 we", reg_we, 1);
        chk("R6 addr", reg_addr, ra);
        chk("R6 wdata", reg_wdata, d);
        exp_mem[ra] = d;
        #1;
        chk("R9 we once", we_cnt - b_we, 1);
        chk("R9 no re", re_cnt - b_re, 0);
        chk("R8 no oe on write", oe_cnt - b_oe, 0);
    endtask

    task automatic do_bad(logic [1:0] op, logic [4:0] dev, logic [4:0] ra);
        int b_re = re_cnt, b_we = we_cnt, b_oe = oe_cnt;
        send_hdr(op, dev, ra, 0);
        @(negedge clk);
        mdio_in = 1;
        chk("R7 no oe", mdio_oe, 0);
        repeat (20) clk_bit(1);
        #1;
        chk("R7 no strobes", (re_cnt - b_re) + (we_cnt - b_we), 0);
        chk("R7 no oe cycles", oe_cnt - b_oe, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int a = 0; a < 32; a++) begin
            mem[a] = init_val(a);
            exp_mem[a] = init_val(a);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", {mdio_oe, mdio_out, reg_re, reg_we}, 4'b0000);
        rst = 0;

        // directed corners
        do_read(5'h00, 5'd0, 0);
        do_read(5'h1F, 5'd31, 3);          // R2: extra start zeros
        do_write(5'h0A, 5'd0, 16'h8001, 0);
        do_write(5'h15, 5'd31, 16'hFFFF, 2);
        do_write(5'h03, 5'd17, 16'h0000, 0);
        do_read(5'h11, 5'd0, 0);
        do_read(5'h02, 5'd31, 1);
        do_read(5'h1C, 5'd17, 0);
        do_bad(2'b00, 5'h04, 5'd4);
        do_bad(2'b11, 5'h1F, 5'd9);
        do_read(5'h07, 5'd9, 0);

        // R1: reset during read data phase
        send_hdr(2'b10, 5'h01, 5'd5, 0);
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1;
        @(posedge clk);
        @(negedge clk); rst = 0;
        chk("R1 mid-frame reset", {mdio_oe, reg_re, reg_we}, 3'b000);
        do_read(5'h01, 5'd5, 0);

        // constrained random frames
        for (int k = 0; k < 60; k++) begin
            int kind = int'($urandom % 8);
            logic [4:0] dev = 5'($urandom);
            logic [4:0] ra  = 5'($urandom);
            int zeros = int'($urandom % 4);
            if (kind < 4)      do_read(dev, ra, zeros);
            else if (kind < 7) do_write(dev, ra, 16'($urandom), zeros);
            else               do_bad(($urandom % 2) ? 2'b11 : 2'b00, dev, ra);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule